// File: doc/BRIEF.md
# VME Slave Address-Space Decoder with Board Registers

This block sits behind the synchronised VME slave pins of a trigger/readout card. It sorts each bus cycle by its address modifier into one of two spaces and answers it. Standard A24 single cycles aimed at this board's slot reach two board registers: an identity word and the A32 window base. A32 cycles whose top nine address bits equal the programmed base reach the data readout window. For those cycles the block pulses a read request to the readout logic and returns the word that logic presents.

The slot number that forms A24 bits [23:19] comes from the geographic address pins in a VME64x crate, or from five switch bits in an older crate. Modifiers reserved for the separate firmware-loading engine are never claimed. The block drives DTACK for one accepted cycle at a time and holds it until the data strobe is released.

Top module: `vme_slave_decoder`

## Requirements
- R1: An A24 cycle is claimed only when address bits [23:19] equal the slot number. The slot number is `geo_addr` when `vme64x_crate` is 1 and `switch_addr` when it is 0.
- R2: Bits [7:0] of the identity register (A24 offset 0x00000) hold a read/write crate ID that resets to 0x00. A write there changes no other bit.
- R3: An identity read returns the board-type code (parameter, default 0x5C) in [31:24] and the build code (parameter, default 0x01 = production, 0x00 = prototype) in [23:16]. It returns zero in [15:13], the slot number in [12:8] and the crate ID in [7:0].
- R4: The A32 base register at A24 offset 0x00010 resets to zero. It stores write data bits [31:23] and reads back with those bits in [31:23] and zeros elsewhere.
- R5: An A32 cycle is claimed when address bits [31:23] equal the stored base and the base is nonzero. A claimed A32 read returns `win_rdata` sampled at acceptance and pulses `win_rd` for one cycle. A claimed A32 write completes with DTACK and changes no register.
- R6: The A24 modifiers claimed are 0x39, 0x3A, 0x3D and 0x3E. The A32 modifiers claimed are 0x09, 0x0A, 0x0B, 0x0D, 0x0E and 0x0F.
- R7: The modifiers 0x19, 0x1A, 0x1D and 0x1E are never answered, whatever the address.
- R8: An A24 read at any unmapped offset in the board's window, offset 0x0FFFC included, returns zero and completes with DTACK. A write there changes no register.
- R9: DTACK rises on the clock edge after the edge at which address strobe, data strobe and a matching decode are first seen together. It stays high while the data strobe is held and falls on the first edge at which the data strobe is inactive.
- R10: A cycle whose modifier or address does not match gets no DTACK and leaves `rd_data` unchanged.
- R11: After reset, `dtack`, `rd_data` and `win_rd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vme64x_crate | input | 1 | 1 selects the geographic address as the slot number |
| geo_addr | input | 5 | Geographic slot number |
| switch_addr | input | 5 | Switch slot number for non-VME64x crates |
| bus_as | input | 1 | Address strobe, active high, synchronised |
| bus_ds | input | 1 | Data strobe (either half), active high, synchronised |
| bus_write | input | 1 | 1 for a write cycle |
| bus_am | input | 6 | Address modifier |
| bus_addr | input | 32 | Bus address |
| bus_wdata | input | 32 | Write data |
| win_rdata | input | 32 | Word presented by the readout window |
| rd_data | output | 32 | Read data, valid while dtack is high |
| dtack | output | 1 | Data acknowledge, active high |
| win_rd | output | 1 | One-cycle read request to the readout window |

## Verification
The assertions take for granted that the strobes and the address, modifier and data lines arrive already synchronised to `clk`. They also assume that address, modifier and write data stay stable from when the data strobe rises until DTACK is seen. The stimulus meets this by changing every bus input only at the falling clock edge. Each cycle is driven as one whole transfer that holds its fields until the acknowledge has arrived, or until a fixed wait has passed for cycles that must go unanswered, and only then drops both strobes. Slot selection is switched between geographic and switch modes only while the bus is idle.

// File: rtl/vme_dec_pkg.sv
package vme_dec_pkg;
  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_A24  = 2'd1,
    SPACE_A32  = 2'd2
  } space_e;
endpackage

// File: rtl/vme_am_classify.sv
module vme_am_classify
  import vme_dec_pkg::*;
#(
  parameter int AM_W = 6
) (
  input  logic [AM_W-1:0] am,
  output space_e          space
);
  always_comb begin
    unique case (am)
      6'h39, 6'h3A, 6'h3D, 6'h3E:               space = SPACE_A24;
      6'h09, 6'h0A, 6'h0B, 6'h0D, 6'h0E, 6'h0F: space = SPACE_A32;
      default:                                  space = SPACE_NONE;
    endcase
  end
endmodule

// File: rtl/vme_board_regs.sv
module vme_board_regs #(
  parameter int          DW         = 32,
  parameter int          OFS_W      = 19,
  parameter int          SLOT_W     = 5,
  parameter int          BASE_W     = 9,
  parameter int          CRATE_W    = 8,
  parameter logic [7:0]  BOARD_TYPE = 8'h5C,
  parameter logic [7:0]  BUILD_CODE = 8'h01,
  parameter logic [OFS_W-1:0] ID_OFS   = '0,
  parameter logic [OFS_W-1:0] BASE_OFS = OFS_W'(16)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DW-1:0]     wdata,
  input  logic [SLOT_W-1:0] slot,
  output logic [DW-1:0]     rdata,
  output logic [BASE_W-1:0] a32_base
);
  localparam int GAP_W = 16 - 8 - SLOT_W;

  logic [CRATE_W-1:0] crate_id;
  logic               unused_wbits;

  assign unused_wbits = ^wdata[DW-BASE_W-1:CRATE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      crate_id <= '0;
      a32_base <= '0;
    end else if (wr_en) begin
      if (offset == ID_OFS)   crate_id <= wdata[CRATE_W-1:0];
      if (offset == BASE_OFS) a32_base <= wdata[DW-1:DW-BASE_W];
    end
  end

  always_comb begin
    if (offset == ID_OFS)
      rdata = {BOARD_TYPE, BUILD_CODE, {GAP_W{1'b0}}, slot, crate_id};
    else if (offset == BASE_OFS)
      rdata = {a32_base, {(DW-BASE_W){1'b0}}};
    else
      rdata = '0;
  end
endmodule

// File: rtl/vme_ack_fsm.sv
module vme_ack_fsm (
  input  logic clk,
  input  logic rst,
  input  logic as_i,
  input  logic ds_i,
  input  logic hit,
  output logic accept,
  output logic dtack
);
  typedef enum logic {ST_IDLE = 1'b0, ST_ACK = 1'b1} st_e;
  st_e st;

  assign accept = (st == ST_IDLE) && as_i && ds_i && hit;
  assign dtack  = (st == ST_ACK);

  always_ff @(posedge clk) begin
    if (rst)
      st <= ST_IDLE;
    else if (st == ST_IDLE && accept)
      st <= ST_ACK;
    else if (st == ST_ACK && !ds_i)
      st <= ST_IDLE;
  end
endmodule

// File: rtl/vme_slave_decoder.sv
module vme_slave_decoder
  import vme_dec_pkg::*;
#(
  parameter int         AW         = 32,
  parameter int         DW         = 32,
  parameter int         AM_W       = 6,
  parameter int         A24_W      = 24,
  parameter int         SLOT_W     = 5,
  parameter int         BASE_W     = 9,
  parameter logic [7:0] BOARD_TYPE = 8'h5C,
  parameter logic [7:0] BUILD_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vme64x_crate,
  input  logic [SLOT_W-1:0] geo_addr,
  input  logic [SLOT_W-1:0] switch_addr,
  input  logic              bus_as,
  input  logic              bus_ds,
  input  logic              bus_write,
  input  logic [AM_W-1:0]   bus_am,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     win_rdata,
  output logic [DW-1:0]     rd_data,
  output logic              dtack,
  output logic              win_rd
);
  localparam int OFS_W = A24_W - SLOT_W;

  space_e            space;
  logic [SLOT_W-1:0] slot;
  logic [BASE_W-1:0] a32_base;
  logic [DW-1:0]     reg_rdata;
  logic              hit_a24, hit_a32, accept, reg_wr;

  assign slot = vme64x_crate ? geo_addr : switch_addr;

  vme_am_classify #(.AM_W(AM_W)) u_am (
    .am    (bus_am),
    .space (space)
  );

  assign hit_a24 = (space == SPACE_A24) && (bus_addr[A24_W-1:OFS_W] == slot);
  assign hit_a32 = (space == SPACE_A32) && (a32_base != '0) &&
                   (bus_addr[AW-1:AW-BASE_W] == a32_base);

  vme_ack_fsm u_ack (
    .clk    (clk),
    .rst    (rst),
    .as_i   (bus_as),
    .ds_i   (bus_ds),
    .hit    (hit_a24 || hit_a32),
    .accept (accept),
    .dtack  (dtack)
  );

  assign reg_wr = accept && hit_a24 && bus_write;

  vme_board_regs #(
    .DW(DW), .OFS_W(OFS_W), .SLOT_W(SLOT_W), .BASE_W(BASE_W),
    .BOARD_TYPE(BOARD_TYPE), .BUILD_CODE(BUILD_CODE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .offset   (bus_addr[OFS_W-1:0]),
    .wdata    (bus_wdata),
    .slot     (slot),
    .rdata    (reg_rdata),
    .a32_base (a32_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      win_rd  <= 1'b0;
    end else begin
      win_rd <= accept && hit_a32 && !bus_write;
      if (accept)
        rd_data <= bus_write ? '0 : (hit_a24 ? reg_rdata : win_rdata);
    end
  end
endmodule

// File: rtl/vme_slave_decoder_chk.sv
module vme_slave_decoder_chk #(
  parameter int AW     = 32,
  parameter int AM_W   = 6,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              vme64x_crate,
  input logic [SLOT_W-1:0] geo_addr,
  input logic [SLOT_W-1:0] switch_addr,
  input logic              bus_as,
  input logic              bus_ds,
  input logic [AM_W-1:0]   bus_am,
  input logic [AW-1:0]     bus_addr,
  input logic              dtack,
  input logic              win_rd
);
  logic user_am, a24_am, wrong_slot;
  assign user_am    = bus_am inside {6'h19, 6'h1A, 6'h1D, 6'h1E};
  assign a24_am     = bus_am inside {6'h39, 6'h3A, 6'h3D, 6'h3E};
  assign wrong_slot = bus_addr[23:19] != (vme64x_crate ? geo_addr : switch_addr);

  assert_ack_needs_strobes_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack) |-> $past(bus_as && bus_ds));
  assert_ack_held_R9: assert property (@(posedge clk) disable iff (rst)
    (dtack && bus_ds) |=> dtack);
  assert_ack_released_R9: assert property (@(posedge clk) disable iff (rst)
    (dtack && !bus_ds) |=> !dtack);
  assert_user_am_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!dtack && user_am) |=> !dtack);
  assert_slot_mismatch_R10: assert property (@(posedge clk) disable iff (rst)
    (!dtack && a24_am && wrong_slot) |=> !dtack);
  assert_win_rd_with_ack_R5: assert property (@(posedge clk) disable iff (rst)
    win_rd |-> $rose(dtack));
  assert_win_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
    win_rd |=> !win_rd);
endmodule

bind vme_slave_decoder vme_slave_decoder_chk #(.AW(AW), .AM_W(AM_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .vme64x_crate(vme64x_crate), .geo_addr(geo_addr),
  .switch_addr(switch_addr), .bus_as(bus_as), .bus_ds(bus_ds), .bus_am(bus_am),
  .bus_addr(bus_addr), .dtack(dtack), .win_rd(win_rd)
);

// File: tb/tb_vme_slave_decoder.sv
`timescale 1ns/1ps
module tb_vme_slave_decoder;
  localparam logic [7:0] TYPE_C  = 8'h5C;
  localparam logic [7:0] BUILD_C = 8'h01;

  logic clk = 1'b0, rst = 1'b1;
  logic vme64x_crate = 1'b1;
  logic [4:0] geo_addr = 5'd5, switch_addr = 5'd3;
  logic bus_as = 0, bus_ds = 0, bus_write = 0;
  logic [5:0] bus_am = '0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, win_rdata = '0;
  logic [31:0] rd_data;
  logic dtack, win_rd;

  int checks = 0, failures = 0, cyc = 0;
  bit started = 0, done = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;

  vme_slave_decoder dut (
    .clk(clk), .rst(rst), .vme64x_crate(vme64x_crate), .geo_addr(geo_addr),
    .switch_addr(switch_addr), .bus_as(bus_as), .bus_ds(bus_ds),
    .bus_write(bus_write), .bus_am(bus_am), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .win_rdata(win_rdata), .rd_data(rd_data),
    .dtack(dtack), .win_rd(win_rd)
  );

  // Behavioural reference model
  logic        m_dtack = 0, m_win = 0;
  logic [31:0] m_rd = 0;
  logic [7:0]  m_crate = 0;
  logic [8:0]  m_base = 0;

  always @(posedge clk) begin
    logic [4:0] s;
    bit h24, h32;
    started = 1;
    if (rst) begin
      m_dtack = 0; m_win = 0; m_rd = 0; m_crate = 0; m_base = 0;
    end else begin
      m_win = 0;
      s   = vme64x_crate ? geo_addr : switch_addr;
      h24 = (bus_am inside {6'h39, 6'h3A, 6'h3D, 6'h3E}) && bus_addr[23:19] == s;
      h32 = (bus_am inside {6'h09, 6'h0A, 6'h0B, 6'h0D, 6'h0E, 6'h0F}) &&
            m_base != 0 && bus_addr[31:23] == m_base;
      if (!m_dtack) begin
        if (bus_as && bus_ds && (h24 || h32)) begin
          m_dtack = 1;
          if (bus_write) begin
            m_rd = 0;
            if (h24 && bus_addr[18:0] == 0)     m_crate = bus_wdata[7:0];
            if (h24 && bus_addr[18:0] == 19'h10) m_base = bus_wdata[31:23];
          end else begin
            m_win = h32;
            if (h32)                          m_rd = win_rdata;
            else if (bus_addr[18:0] == 0)     m_rd = {TYPE_C, BUILD_C, 3'b000, s, m_crate};
            else if (bus_addr[18:0] == 19'h10) m_rd = {m_base, 23'd0};
            else                              m_rd = 0;
          end
        end
      end else if (!bus_ds) m_dtack = 0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    win_rdata <= 32'hD000_0000 + cyc;
    if (started && !done) begin
      checks++;
      if (dtack !== m_dtack || rd_data !== m_rd || win_rd !== m_win) begin
        failures++;
        $display("FAIL %s cycle %0d: dtack=%b rd=%h win=%b expected dtack=%b rd=%h win=%b",
                 cur_req, cyc, dtack, rd_data, win_rd, m_dtack, m_rd, m_win);
      end
    end
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input string req, input bit wr, input logic [5:0] am,
                     input logic [31:0] a, input logic [31:0] d,
                     input bit exp_ack, input bit chk_rd, input logic [31:0] exp_rd,
                     input int hold = 0);
    bit got = 0;
    logic [31:0] rd_before;
    cur_req = req;
    @(negedge clk); #1;
    rd_before = rd_data;
    bus_write = wr; bus_am = am; bus_addr = a; bus_wdata = d;
    bus_as = 1; bus_ds = 1;
    for (int i = 0; i < 6 && !got; i++) begin
      @(negedge clk);
      if (dtack) got = 1;
    end
    chk({req, " ack"}, 32'(got), 32'(exp_ack));
    if (got && chk_rd) chk({req, " data"}, rd_data, exp_rd);
    if (!got) chk({req, " rd_data unchanged"}, rd_data, rd_before);
    repeat (hold) @(negedge clk);
    if (hold > 0) chk({req, " ack held"}, 32'(dtack), 32'd1);
    #1; bus_ds = 0; bus_as = 0;
    repeat (2) @(negedge clk);
    chk({req, " ack released"}, 32'(dtack), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 dtack reset", 32'(dtack), 0);
    chk("R11 rd_data reset", rd_data, 0);
    chk("R11 win_rd reset", 32'(win_rd), 0);
    #1; rst = 0;
    repeat (2) @(negedge clk);

    // slot 5 via geographic address -> A24 window 0x28xxxx
    bus("R3 identity read", 0, 6'h39, 32'h0028_0000, 0, 1, 1, 32'h5C01_0500);
    bus("R2 crate id write", 1, 6'h3D, 32'hFF28_0000, 32'hFFFF_FFA5, 1, 0, 0);
    bus("R2 crate id readback", 0, 6'h3A, 32'h0028_0000, 0, 1, 1, 32'h5C01_05A5);
    bus("R4 base reset value", 0, 6'h3E, 32'h0028_0010, 0, 1, 1, 32'h0);
    bus("R5 A32 refused while base zero", 0, 6'h09, 32'h0000_0040, 0, 0, 0, 0);
    bus("R4 base write", 1, 6'h39, 32'h0028_0010, 32'hABCD_1234, 1, 0, 0);
    bus("R4 base readback", 0, 6'h39, 32'h0028_0010, 0, 1, 1, 32'hAB80_0000);
    bus("R5 A32 read", 0, 6'h09, 32'hAB80_0040, 0, 1, 0, 0);
    bus("R6 A32 block modifier", 0, 6'h0B, 32'hABFF_FFFC, 0, 1, 0, 0);
    bus("R6 A32 modifier 0x0F", 0, 6'h0F, 32'hAB80_0000, 0, 1, 0, 0);
    bus("R5 A32 write acked", 1, 6'h0D, 32'hAB80_0000, 32'h1234_5678, 1, 0, 0);
    bus("R2 crate id after A32 write", 0, 6'h39, 32'h0028_0000, 0, 1, 1, 32'h5C01_05A5);
    bus("R10 A32 outside window", 0, 6'h0A, 32'hAC00_0000, 0, 0, 0, 0);
    bus("R7 user modifier write", 1, 6'h19, 32'h0028_FFFC, 32'h3, 0, 0, 0);
    bus("R7 user modifier read", 0, 6'h1E, 32'h0028_0000, 0, 0, 0, 0);
    bus("R8 unmapped 0x0FFFC read", 0, 6'h39, 32'h0028_FFFC, 0, 1, 1, 32'h0);
    bus("R8 unmapped write", 1, 6'h39, 32'h0028_0004, 32'hFFFF_FFFF, 1, 0, 0);
    bus("R8 unmapped read", 0, 6'h3D, 32'h0028_0004, 0, 1, 1, 32'h0);
    bus("R8 base unchanged", 0, 6'h39, 32'h0028_0010, 0, 1, 1, 32'hAB80_0000);
    bus("R10 wrong slot", 0, 6'h39, 32'h0030_0000, 0, 0, 0, 0);
    bus("R10 unclaimed modifier", 0, 6'h2D, 32'h0028_0000, 0, 0, 0, 0);
    bus("R9 long strobe", 0, 6'h39, 32'h0028_0000, 0, 1, 1, 32'h5C01_05A5, 5);

    // switch mode: slot 3 -> window 0x18xxxx
    @(negedge clk); #1; vme64x_crate = 0;
    bus("R1 switch slot read", 0, 6'h39, 32'h0018_0000, 0, 1, 1, 32'h5C01_03A5);
    bus("R1 geographic slot ignored", 0, 6'h39, 32'h0028_0000, 0, 0, 0, 0);
    @(negedge clk); #1; vme64x_crate = 1;
    bus("R1 geographic slot again", 0, 6'h39, 32'h0028_0000, 0, 1, 1, 32'h5C01_05A5);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule